// File: doc/BRIEF.md
# Address-Match Breakpoint Trigger Unit

This block is a small bank of hardware breakpoint triggers for a 64-bit processor hart. Software reaches the triggers only indirectly. A select register picks one trigger, and two data registers then show that trigger's control word and its match address. All three sit behind a simple CSR-style port: a write strobe, a 2-bit register code, write data and combinational read data. Writes to the select register and the control word pass a legality filter first. A value the hardware cannot hold therefore reads back changed, and software can use this to probe how many triggers exist and which enables they support.

Each trigger compares its full-width match address against the instruction-fetch address and the load/store address that the pipeline presents in the same cycle. A hit raises one breakpoint exception request in that same cycle. The request carries the breakpoint cause code and the PC of the instruction that matched. The memory access of the cycle is also killed, so a matching store never commits. The pipeline, the trap vector and return logic, chaining and range matching all live outside this block.

Top module: `brkpt_top`

## Requirements
- R1: After reset, the select register reads 0x8000_0000_0000_0000 (bit 63 set, index 0). For every trigger, the control register reads 0x1000_0000_0000_0000 (type code 1 in bits 63:60, every enable clear). No breakpoint request is raised.
- R2: A select write with the following properties takes effect:
  - bit 63 is set;
  - bits 62 down to the index width are zero;
  - the index is below the trigger count.
  
  Any other select write leaves the select register unchanged, so its readback differs from the value written.
- R3: A control write keeps only four bits. These are machine-mode enable (bit 6), execute (bit 2), store (bit 1) and load (bit 0). Every other bit in 59:0 reads back zero, and bits 63:60 always read 1.
- R4: Execute cannot be combined with load or store. A control write with bit 2 set stores the load and store enables as zero.
- R5: Code 2 reads and writes the full 64-bit match address of the selected trigger. Code 3 reads zero.
- R6: A fetch hit raises the request when all of the following hold:
  - machine mode is active;
  - the trigger's machine-mode and execute enables are set;
  - the fetch address equals the match address.
  
  The hit reports cause 3 and EPC equal to the fetch address. A load from that address with only execute enabled raises nothing.
- R7: With load enabled, a load whose address equals the match address raises the request with EPC equal to memPc. A store to that address with only load enabled raises nothing.
- R8: With store enabled, a store to the match address raises the request and drives storeCommit low. A store that hits no trigger drives storeCommit high.
- R9: No trigger fires in either of these cases: the hart is outside machine mode, or the trigger's machine-mode enable is clear. The compare uses all 64 address bits.
- R10: Triggers are independent. Writing one trigger leaves every other trigger's registers unchanged, and a hit on any trigger raises the request.
- R11: When a fetch hit and a load/store hit fall in the same cycle, the block raises a single request. That request has EPC equal to the fetch address, memKill high and storeCommit low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csrWrEn | input | 1 | Register write strobe |
| csrSel | input | 2 | Register code: 0 select, 1 control, 2 match address, 3 none |
| csrWrData | input | 64 | Register write data |
| csrRdData | output | 64 | Combinational readback of the coded register |
| machineMode | input | 1 | Hart currently in machine mode |
| fetchValid | input | 1 | Instruction fetch presented this cycle |
| fetchAddr | input | 64 | Fetch address (also the PC of the fetched instruction) |
| memValid | input | 1 | Load or store presented this cycle |
| memIsStore | input | 1 | 1 for store, 0 for load |
| memAddr | input | 64 | Load/store data address |
| memPc | input | 64 | PC of the load/store instruction |
| bkptReq | output | 1 | Breakpoint exception request |
| bkptCause | output | 64 | Cause code 3 while requesting, else zero |
| bkptEpc | output | 64 | PC of the matching instruction while requesting, else zero |
| storeCommit | output | 1 | Presented store may write memory |
| memKill | output | 1 | Presented load/store is cancelled by a breakpoint |

## Verification
Two functions can collide in one cycle: a fetch match and a load/store match. The collision can happen across two triggers or on one trigger's address. The bench arms one trigger for execute and another for store, then presents a matching fetch and a matching store together. It judges the outcome against R11: one request, the fetch address as EPC, and the store killed. A register write that lands in the same cycle as a matching access is also exercised. The reference model uses pre-edge state for that cycle's match and post-edge state for the next.

// File: rtl/brkpt_pkg.sv
package brkpt_pkg;

  // control bit positions inside the control register
  localparam int CB_READ  = 0;
  localparam int CB_WRITE = 1;
  localparam int CB_EXEC  = 2;
  localparam int CB_MMODE = 6;

  localparam logic [3:0] TYPE_ADDR_MATCH = 4'd1;
  localparam int         CAUSE_BKPT      = 3;

  typedef enum logic [1:0] {
    CSR_SELECT = 2'd0,
    CSR_CTRL   = 2'd1,
    CSR_ADDR   = 2'd2,
    CSR_NONE   = 2'd3
  } csrSel_e;

  typedef struct packed {
    logic mEn;
    logic xEn;
    logic wEn;
    logic rEn;
  } trigCtrl_t;

  typedef struct packed {
    logic selWr;
    logic ctrlWr;
    logic addrWr;
  } trigStrobe_t;

endpackage

// File: rtl/brkpt_cmp.sv
module brkpt_cmp
  import brkpt_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  trigCtrl_t        ctrl,
  input  logic [XLEN-1:0]  matchAddr,
  input  logic             machineMode,
  input  logic             fetchValid,
  input  logic [XLEN-1:0]  fetchAddr,
  input  logic             memValid,
  input  logic             memIsStore,
  input  logic [XLEN-1:0]  memAddr,
  output logic             fetchHit,
  output logic             memHit
);

  logic armed;
  logic accessEn;

  assign armed    = machineMode & ctrl.mEn;
  assign accessEn = memIsStore ? ctrl.wEn : ctrl.rEn;

  assign fetchHit = fetchValid & armed & ctrl.xEn & (fetchAddr == matchAddr);
  assign memHit   = memValid & armed & accessEn & (memAddr == matchAddr);

endmodule

// File: rtl/brkpt_ctrl.sv
module brkpt_ctrl
  import brkpt_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int NUM_TRIG = 2,
  parameter int IDX_W    = 1
) (
  input  logic              csrWrEn,
  input  logic [1:0]        csrSel,
  input  logic [XLEN-1:0]   csrWrData,
  input  logic [IDX_W-1:0]  selIdx,
  input  trigCtrl_t         selCtrl,
  input  logic [XLEN-1:0]   selAddr,
  output trigStrobe_t       strobe,
  output trigCtrl_t         wrCtrl,
  output logic [XLEN-1:0]   wrData,
  output logic [XLEN-1:0]   csrRdData
);

  csrSel_e selCode;
  logic    hiClear;
  logic    idxInRange;
  logic    selLegal;

  assign selCode    = csrSel_e'(csrSel);
  assign hiClear    = (csrWrData[XLEN-2:IDX_W] == '0);
  assign idxInRange = ({1'b0, csrWrData[IDX_W-1:0]} < (IDX_W+1)'(NUM_TRIG));
  assign selLegal   = csrWrData[XLEN-1] & hiClear & idxInRange;

  always_comb begin
    strobe.selWr  = csrWrEn && (selCode == CSR_SELECT) && selLegal;
    strobe.ctrlWr = csrWrEn && (selCode == CSR_CTRL);
    strobe.addrWr = csrWrEn && (selCode == CSR_ADDR);
  end

  // legality filter: execute excludes load/store enables
  always_comb begin
    wrCtrl.mEn = csrWrData[CB_MMODE];
    wrCtrl.xEn = csrWrData[CB_EXEC];
    wrCtrl.wEn = csrWrData[CB_WRITE] & ~csrWrData[CB_EXEC];
    wrCtrl.rEn = csrWrData[CB_READ]  & ~csrWrData[CB_EXEC];
  end

  assign wrData = csrWrData;

  always_comb begin
    csrRdData = '0;
    unique case (selCode)
      CSR_SELECT: begin
        csrRdData[XLEN-1]    = 1'b1;
        csrRdData[IDX_W-1:0] = selIdx;
      end
      CSR_CTRL: begin
        csrRdData[XLEN-1 -: 4] = TYPE_ADDR_MATCH;
        csrRdData[CB_MMODE]    = selCtrl.mEn;
        csrRdData[CB_EXEC]     = selCtrl.xEn;
        csrRdData[CB_WRITE]    = selCtrl.wEn;
        csrRdData[CB_READ]     = selCtrl.rEn;
      end
      CSR_ADDR: csrRdData = selAddr;
      default:  csrRdData = '0;
    endcase
  end

endmodule

// File: rtl/brkpt_dp.sv
module brkpt_dp
  import brkpt_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int NUM_TRIG = 2,
  parameter int IDX_W    = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  trigStrobe_t       strobe,
  input  trigCtrl_t         wrCtrl,
  input  logic [XLEN-1:0]   wrData,
  input  logic              machineMode,
  input  logic              fetchValid,
  input  logic [XLEN-1:0]   fetchAddr,
  input  logic              memValid,
  input  logic              memIsStore,
  input  logic [XLEN-1:0]   memAddr,
  input  logic [XLEN-1:0]   memPc,
  output logic [IDX_W-1:0]  selIdx,
  output trigCtrl_t         selCtrl,
  output logic [XLEN-1:0]   selAddr,
  output logic              bkptReq,
  output logic [XLEN-1:0]   bkptCause,
  output logic [XLEN-1:0]   bkptEpc,
  output logic              storeCommit,
  output logic              memKill
);

  trigCtrl_t            ctrlArr [NUM_TRIG];
  logic [XLEN-1:0]      addrArr [NUM_TRIG];
  logic [NUM_TRIG-1:0]  fetchHitVec;
  logic [NUM_TRIG-1:0]  memHitVec;
  logic                 anyFetch;
  logic                 anyMem;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             selIdx <= '0;
    else if (strobe.selWr) selIdx <= wrData[IDX_W-1:0];
  end

  for (genvar t = 0; t < NUM_TRIG; t++) begin : g_trig
    trigCtrl_t       ctrlQ;
    logic [XLEN-1:0] addrQ;
    logic            isSel;

    assign isSel = (selIdx == IDX_W'(t));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ctrlQ <= '0;
        addrQ <= '0;
      end else begin
        if (strobe.ctrlWr && isSel) ctrlQ <= wrCtrl;
        if (strobe.addrWr && isSel) addrQ <= wrData;
      end
    end

    assign ctrlArr[t] = ctrlQ;
    assign addrArr[t] = addrQ;

    brkpt_cmp #(.XLEN(XLEN)) u_cmp (
      .ctrl        (ctrlQ),
      .matchAddr   (addrQ),
      .machineMode (machineMode),
      .fetchValid  (fetchValid),
      .fetchAddr   (fetchAddr),
      .memValid    (memValid),
      .memIsStore  (memIsStore),
      .memAddr     (memAddr),
      .fetchHit    (fetchHitVec[t]),
      .memHit      (memHitVec[t])
    );
  end

  assign selCtrl = ctrlArr[selIdx];
  assign selAddr = addrArr[selIdx];

  assign anyFetch = |fetchHitVec;
  assign anyMem   = |memHitVec;
  assign bkptReq  = anyFetch | anyMem;

  // fetch hit takes priority over a load/store hit
  always_comb begin
    bkptCause = '0;
    bkptEpc   = '0;
    if (bkptReq) begin
      bkptCause = XLEN'(CAUSE_BKPT);
      bkptEpc   = anyFetch ? fetchAddr : memPc;
    end
  end

  assign memKill     = memValid & bkptReq;
  assign storeCommit = memValid & memIsStore & ~bkptReq;

endmodule

// File: rtl/brkpt_top.sv
module brkpt_top
  import brkpt_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int NUM_TRIG = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csrWrEn,
  input  logic [1:0]       csrSel,
  input  logic [XLEN-1:0]  csrWrData,
  output logic [XLEN-1:0]  csrRdData,
  input  logic             machineMode,
  input  logic             fetchValid,
  input  logic [XLEN-1:0]  fetchAddr,
  input  logic             memValid,
  input  logic             memIsStore,
  input  logic [XLEN-1:0]  memAddr,
  input  logic [XLEN-1:0]  memPc,
  output logic             bkptReq,
  output logic [XLEN-1:0]  bkptCause,
  output logic [XLEN-1:0]  bkptEpc,
  output logic             storeCommit,
  output logic             memKill
);

  localparam int IDX_W = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;

  trigStrobe_t      strobe;
  trigCtrl_t        wrCtrl;
  trigCtrl_t        selCtrl;
  logic [XLEN-1:0]  wrData;
  logic [XLEN-1:0]  selAddr;
  logic [IDX_W-1:0] selIdx;

  brkpt_ctrl #(.XLEN(XLEN), .NUM_TRIG(NUM_TRIG), .IDX_W(IDX_W)) u_ctrl (
    .csrWrEn   (csrWrEn),
    .csrSel    (csrSel),
    .csrWrData (csrWrData),
    .selIdx    (selIdx),
    .selCtrl   (selCtrl),
    .selAddr   (selAddr),
    .strobe    (strobe),
    .wrCtrl    (wrCtrl),
    .wrData    (wrData),
    .csrRdData (csrRdData)
  );

  brkpt_dp #(.XLEN(XLEN), .NUM_TRIG(NUM_TRIG), .IDX_W(IDX_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wrCtrl      (wrCtrl),
    .wrData      (wrData),
    .machineMode (machineMode),
    .fetchValid  (fetchValid),
    .fetchAddr   (fetchAddr),
    .memValid    (memValid),
    .memIsStore  (memIsStore),
    .memAddr     (memAddr),
    .memPc       (memPc),
    .selIdx      (selIdx),
    .selCtrl     (selCtrl),
    .selAddr     (selAddr),
    .bkptReq     (bkptReq),
    .bkptCause   (bkptCause),
    .bkptEpc     (bkptEpc),
    .storeCommit (storeCommit),
    .memKill     (memKill)
  );

endmodule

// File: rtl/brkpt_chk.sv
module brkpt_chk
  import brkpt_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IDX_W = 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             csrWrEn,
  input logic [1:0]       csrSel,
  input logic [XLEN-1:0]  csrWrData,
  input logic [IDX_W-1:0] selIdx,
  input trigStrobe_t      strobe,
  input trigCtrl_t        wrCtrl,
  input logic             machineMode,
  input logic [XLEN-1:0]  fetchAddr,
  input logic             memValid,
  input logic [XLEN-1:0]  bkptEpc,
  input logic             bkptReq,
  input logic             storeCommit
);

  // R2: select write without bit 63 leaves the index alone
  assert_sel_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (csrWrEn && csrSel == 2'd0 && !csrWrData[XLEN-1]) |=> $stable(selIdx));

  // R2: at most one register strobe per cycle
  assert_strobe_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.selWr, strobe.ctrlWr, strobe.addrWr}));

  // R4: a stored control never mixes execute with load/store
  assert_ctrl_legal_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ctrlWr |-> !(wrCtrl.xEn && (wrCtrl.wEn || wrCtrl.rEn)));

  // R8: a breakpoint request never lets a store commit
  assert_no_commit_R8: assert property (@(posedge clk) disable iff (!rstN)
    bkptReq |-> !storeCommit);

  // R9: outside machine mode no request
  assert_mode_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    !machineMode |-> !bkptReq);

  // R11: an EPC other than the fetch address needs a memory access present
  assert_epc_src_R11: assert property (@(posedge clk) disable iff (!rstN)
    (bkptReq && bkptEpc != fetchAddr) |-> memValid);

endmodule

bind brkpt_top brkpt_chk #(.XLEN(XLEN), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .csrWrEn     (csrWrEn),
  .csrSel      (csrSel),
  .csrWrData   (csrWrData),
  .selIdx      (selIdx),
  .strobe      (strobe),
  .wrCtrl      (wrCtrl),
  .machineMode (machineMode),
  .fetchAddr   (fetchAddr),
  .memValid    (memValid),
  .bkptEpc     (bkptEpc),
  .bkptReq     (bkptReq),
  .storeCommit (storeCommit)
);

// File: tb/sim_brkpt_top.sv
`timescale 1ns/1ps
module sim_brkpt_top;

  localparam int NT = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csrWrEn = 1'b0;
  logic [1:0]  csrSel = 2'd3;
  logic [63:0] csrWrData = '0;
  logic [63:0] csrRdData;
  logic        machineMode = 1'b1;
  logic        fetchValid = 1'b0;
  logic [63:0] fetchAddr = '0;
  logic        memValid = 1'b0;
  logic        memIsStore = 1'b0;
  logic [63:0] memAddr = '0;
  logic [63:0] memPc = '0;
  logic        bkptReq;
  logic [63:0] bkptCause;
  logic [63:0] bkptEpc;
  logic        storeCommit;
  logic        memKill;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // behavioural reference state
  int          mIdx;
  logic [63:0] mCtrl [NT];
  logic [63:0] mAddr [NT];

  localparam logic [63:0] A_ADR = 64'h0000_0000_8000_1000;
  localparam logic [63:0] B_ADR = 64'h0000_0000_8000_2000;
  localparam logic [63:0] C_ADR = 64'h0000_0000_8000_2004;
  localparam logic [63:0] TOP   = 64'h8000_0000_0000_0000;

  always #2.5 clk = ~clk;

  brkpt_top u0 (.*);

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic modelReset();
    mIdx = 0;
    for (int t = 0; t < NT; t++) begin
      mCtrl[t] = '0;
      mAddr[t] = '0;
    end
  endtask

  // one clock: compare combinational outputs, then advance model at the edge
  task automatic step(input string tag);
    logic [63:0] expRd;
    logic        anyF, anyM, req;
    #1;
    if (rstN) begin
      case (csrSel)
        2'd0: expRd = TOP | 64'(mIdx);
        2'd1: expRd = (64'h1 << 60) | mCtrl[mIdx];
        2'd2: expRd = mAddr[mIdx];
        default: expRd = '0;
      endcase
      anyF = 0; anyM = 0;
      for (int t = 0; t < NT; t++) begin
        if (fetchValid && machineMode && mCtrl[t][6] && mCtrl[t][2] && mAddr[t] == fetchAddr) anyF = 1;
        if (memValid && machineMode && mCtrl[t][6] &&
            (memIsStore ? mCtrl[t][1] : mCtrl[t][0]) && mAddr[t] == memAddr) anyM = 1;
      end
      req = anyF | anyM;
      chk(tag, "csrRdData", csrRdData, expRd);
      chk(tag, "bkptReq", 64'(bkptReq), 64'(req));
      chk(tag, "bkptCause", bkptCause, req ? 64'd3 : 64'd0);
      chk(tag, "bkptEpc", bkptEpc, !req ? 64'd0 : (anyF ? fetchAddr : memPc));
      chk(tag, "storeCommit", 64'(storeCommit), 64'(memValid && memIsStore && !req));
      chk(tag, "memKill", 64'(memKill), 64'(memValid && req));
    end
    @(posedge clk);
    if (!rstN) modelReset();
    else if (csrWrEn) begin
      case (csrSel)
        2'd0: if (csrWrData[63] && (csrWrData & ~TOP) < 64'(NT)) mIdx = int'(csrWrData[7:0]);
        2'd1: begin
          logic [63:0] c;
          c = csrWrData & 64'h47;
          if (c[2]) c = c & ~64'h3;
          mCtrl[mIdx] = c;
        end
        2'd2: mAddr[mIdx] = csrWrData;
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic idle();
    csrWrEn = 0; csrSel = 2'd3; csrWrData = '0;
    fetchValid = 0; memValid = 0; memIsStore = 0; machineMode = 1;
  endtask

  task automatic csrWr(input logic [1:0] sel, input logic [63:0] d, input string tag);
    idle(); csrWrEn = 1; csrSel = sel; csrWrData = d;
    step(tag);
  endtask

  task automatic csrRd(input logic [1:0] sel, input string tag);
    idle(); csrSel = sel;
    step(tag);
  endtask

  task automatic acc(input logic fv, input logic [63:0] fa, input logic mv, input logic st,
                     input logic [63:0] ma, input logic [63:0] pc, input logic mode, input string tag);
    idle();
    fetchValid = fv; fetchAddr = fa; memValid = mv; memIsStore = st;
    memAddr = ma; memPc = pc; machineMode = mode;
    step(tag);
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    modelReset();
    idle();
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1: reset values, both triggers
    csrRd(2'd0, "R1");
    csrRd(2'd1, "R1");
    chk("R1", "ctrl reset literal", csrRdData, 64'h1000_0000_0000_0000);
    acc(1, 64'd0, 1, 1, 64'd0, 64'h40, 1, "R1");
    csrWr(2'd0, TOP | 1, "R2");
    csrRd(2'd1, "R1");
    csrRd(2'd2, "R1");

    // R2: select legality
    csrRd(2'd0, "R2");
    csrWr(2'd0, TOP | 2, "R2");
    csrRd(2'd0, "R2");
    chk("R2", "select held literal", csrRdData, TOP | 1);
    csrWr(2'd0, 64'd0, "R2");
    csrRd(2'd0, "R2");
    csrWr(2'd0, TOP | 64'h20, "R2");
    csrRd(2'd0, "R2");
    csrWr(2'd0, TOP, "R2");
    csrRd(2'd0, "R2");

    // R3 / R4: control filtering
    csrWr(2'd1, 64'hFFFF_FFFF_FFFF_FFFF, "R4");
    csrRd(2'd1, "R4");
    chk("R4", "exec drops rw", csrRdData, 64'h1000_0000_0000_0044);
    csrWr(2'd1, 64'h0000_0000_0000_07FB, "R3");
    csrRd(2'd1, "R3");
    chk("R3", "mask literal", csrRdData, 64'h1000_0000_0000_0043);
    csrWr(2'd1, 64'h45, "R4");
    csrRd(2'd1, "R4");

    // R5: match address full width, code 3 reads zero
    csrWr(2'd2, 64'hDEAD_BEEF_0123_4567, "R5");
    csrRd(2'd2, "R5");
    chk("R5", "addr literal", csrRdData, 64'hDEAD_BEEF_0123_4567);
    csrWr(2'd3, 64'h1234, "R5");
    csrRd(2'd3, "R5");

    // R6: execute trigger on trigger 0
    csrWr(2'd1, 64'h44, "R6");
    csrWr(2'd2, A_ADR, "R6");
    acc(1, A_ADR, 0, 0, 0, 0, 1, "R6");
    chk("R6", "epc literal", bkptEpc, A_ADR);
    acc(1, A_ADR + 4, 0, 0, 0, 0, 1, "R6");
    acc(0, 0, 1, 0, A_ADR, 64'h100, 1, "R6");
    acc(1, A_ADR ^ TOP, 0, 0, 0, 0, 1, "R9");

    // R9: mode and machine-enable gating
    acc(1, A_ADR, 0, 0, 0, 0, 0, "R9");
    csrWr(2'd1, 64'h04, "R9");
    acc(1, A_ADR, 0, 0, 0, 0, 1, "R9");

    // R7: load trigger
    csrWr(2'd1, 64'h41, "R7");
    csrWr(2'd2, B_ADR, "R7");
    acc(0, 0, 1, 0, B_ADR, 64'h200, 1, "R7");
    chk("R7", "epc literal", bkptEpc, 64'h200);
    acc(0, 0, 1, 1, B_ADR, 64'h204, 1, "R7");

    // R8: store trigger
    csrWr(2'd1, 64'h42, "R8");
    acc(0, 0, 1, 1, B_ADR, 64'h208, 1, "R8");
    chk("R8", "store blocked", 64'(storeCommit), 64'd0);
    acc(0, 0, 1, 1, B_ADR + 8, 64'h20C, 1, "R8");
    chk("R8", "store passes", 64'(storeCommit), 64'd1);

    // R10: second trigger independent
    csrWr(2'd0, TOP | 1, "R10");
    csrWr(2'd1, 64'h41, "R10");
    csrWr(2'd2, C_ADR, "R10");
    csrWr(2'd0, TOP, "R10");
    csrRd(2'd1, "R10");
    csrRd(2'd2, "R10");
    acc(0, 0, 1, 0, C_ADR, 64'h300, 1, "R10");
    acc(0, 0, 1, 1, B_ADR, 64'h304, 1, "R10");
    acc(0, 0, 1, 1, C_ADR, 64'h308, 1, "R10");

    // R11: fetch and store hit in the same cycle
    csrWr(2'd0, TOP | 1, "R11");
    csrWr(2'd1, 64'h44, "R11");
    csrWr(2'd2, A_ADR, "R11");
    acc(1, A_ADR, 1, 1, B_ADR, 64'h400, 1, "R11");
    chk("R11", "epc is fetch", bkptEpc, A_ADR);
    chk("R11", "kill", 64'(memKill), 64'd1);
    acc(1, A_ADR, 1, 0, B_ADR, 64'h404, 1, "R11");

    // write landing together with a matching access
    idle(); csrWrEn = 1; csrSel = 2'd2; csrWrData = C_ADR;
    fetchValid = 1; fetchAddr = A_ADR; step("R10");
    acc(1, A_ADR, 0, 0, 0, 0, 1, "R10");

    // mixed pattern sweep
    for (int i = 0; i < 48; i++) begin
      logic [63:0] ad;
      case (i % 4)
        0: ad = A_ADR; 1: ad = B_ADR; 2: ad = C_ADR; default: ad = A_ADR + 4;
      endcase
      acc(i[0], ad, i[1] | i[2], i[2], (i % 3 == 0) ? B_ADR : C_ADR, 64'(i * 4), (i % 7) != 0, "R11");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule